// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block sits between rename and issue in an out-of-order core. It keeps one availability bit per physical register and, for every register, a mask of the issue slots whose instructions still wait on it. An instruction enters through the insert channel. The insert names a slot, up to two source registers and an optional destination register. Each source whose value is still pending makes the slot a dependent of that register. A destination marks its register as pending. A completion names one register: it marks the register available and clears that register's whole dependent mask in one event. A slot raises its ready line once, for one cycle, when none of its sources are still pending.

Integer and floating-point registers share one physical index space. Each operand is given as a class flag plus an index within its class. Floating-point index k maps to physical register NUM_INT_REGS + k, and integer index k maps to k.

The insert channel follows valid/ready rules. A transfer happens on a clock edge where `ins_valid` and `ins_ready` are both high. `ins_ready` is a combinational function of `ins_slot`. It is low while the addressed slot is occupied, meaning the slot was inserted and has not yet pulsed ready. A producer holding `ins_valid` with stable fields waits until the slot frees. Completions and the ready pulses carry no handshake and cannot be stalled.

Top module: `wakeup_scoreboard`

## Requirements
- R1: After reset every slot_ready bit is 0, ins_ready is 1 for any slot, and every physical register counts as available.
- R2: An operand with class flag 1 (floating point) and index k names physical register NUM_INT_REGS+k. An operand with class flag 0 and index k names register k. Integer k and floating-point k are tracked independently.
- R3: An accepted insert with ins_dst_en=1 makes its destination register pending. A completion makes its register available. When both name the same register in the same cycle, the register ends pending.
- R4: An accepted insert whose enabled sources are all available (or that has none enabled) raises slot_ready for its slot in the cycle after the accepting edge.
- R5: A source that is pending at insert makes the slot a dependent of that register. One completion of that register releases every dependent slot. A released slot whose last pending source this was pulses ready in the cycle after the completion edge.
- R6: A slot with two pending sources stays not ready after only one of them completes. It pulses ready only after both have completed.
- R7: A source equal to the register completing in the same cycle as the insert counts as available.
- R8: slot_ready for a slot is high for exactly one cycle per accepted insert. No slot pulses ready without an insert.
- R9: ins_ready is 0 while the addressed slot is occupied. An insert offered then is not taken and changes no slot or register state.
- R10: A completion of a register that has no dependents wakes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Addressed slot can take an insert |
| ins_slot | input | $clog2(NUM_SLOTS) | Slot receiving the instruction |
| ins_src0_en | input | 1 | First source present |
| ins_src0_fp | input | 1 | First source is a floating-point register |
| ins_src0_idx | input | IDX_W | First source index within its class |
| ins_src1_en | input | 1 | Second source present |
| ins_src1_fp | input | 1 | Second source is a floating-point register |
| ins_src1_idx | input | IDX_W | Second source index within its class |
| ins_dst_en | input | 1 | Instruction writes a destination |
| ins_dst_fp | input | 1 | Destination is a floating-point register |
| ins_dst_idx | input | IDX_W | Destination index within its class |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_fp | input | 1 | Completing register is floating point |
| cmp_idx | input | IDX_W | Completing register index within its class |
| slot_ready | output | NUM_SLOTS | One-cycle ready pulse per slot |

## Verification
The wakeup path is driven with four kinds of pattern. Inserts with no pending sources show the fixed one-cycle insert-to-ready latency. A chain of producer and consumers shows that a consumer is held until its producer completes. A slot with two pending sources is completed one source at a time, which separates all-sources gating from any-source gating. A single completion with three dependents shows that the whole dependent mask is released in one event. Other patterns reuse the same integer and floating-point index with different classes, and coincide an insert with a completion of its source or of its destination. These expose index aliasing, a missing same-cycle bypass, and a wrong priority between clearing and setting a register. A refused insert into an occupied slot, carrying a source that never completes, shows that back-pressure leaves no trace.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // Operand positions within one insert.
  localparam int OP_SRC0  = 0;
  localparam int OP_SRC1  = 1;
  localparam int OP_DST   = 2;
  localparam int NUM_OPS  = 3;
  localparam int NUM_SRCS = 2;
endpackage

// File: rtl/wsb_regfold.sv
module wsb_regfold #(
  parameter int NUM_INT = 16,
  parameter int IDX_W   = 4,
  parameter int REG_W   = 5
) (
  input  logic             is_fp,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] phys
);
  // Floating-point registers are numbered directly after the integer ones.
  assign phys = is_fp ? (REG_W'(NUM_INT) + REG_W'(idx)) : REG_W'(idx);
endmodule

// File: rtl/wsb_avail.sv
module wsb_avail #(
  parameter int NREG  = 32,
  parameter int REG_W = 5,
  parameter int NRD   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [REG_W-1:0]     set_reg,
  input  logic                 clr_en,
  input  logic [REG_W-1:0]     clr_reg,
  input  logic [REG_W-1:0]     rd_reg [NRD],
  output logic [NRD-1:0]       rd_avail
);
  logic [NREG-1:0] bits;

  // A new producer wins over a completion of the same register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits <= '1;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (clr_en && clr_reg == REG_W'(r))
          bits[r] <= 1'b0;
        else if (set_en && set_reg == REG_W'(r))
          bits[r] <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_avail[k] = bits[rd_reg[k]];
  end

  assert_clr_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !bits[$past(clr_reg)]);

  assert_set_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_reg == set_reg)) |=> bits[$past(set_reg)]);
endmodule

// File: rtl/wsb_depmat.sv
module wsb_depmat #(
  parameter int NREG   = 32,
  parameter int SLOTS  = 8,
  parameter int REG_W  = 5,
  parameter int SLOT_W = 3,
  parameter int NADD   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NADD-1:0]    add_en,
  input  logic [REG_W-1:0]   add_reg [NADD],
  input  logic [SLOT_W-1:0]  add_slot,
  input  logic               wake_en,
  input  logic [REG_W-1:0]   wake_reg,
  output logic [SLOTS-1:0]   waiting
);
  logic [SLOTS-1:0] dep    [NREG];
  logic [SLOTS-1:0] dep_nx [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      dep_nx[r] = dep[r];
      if (wake_en && wake_reg == REG_W'(r))
        dep_nx[r] = '0;
      for (int k = 0; k < NADD; k++) begin
        if (add_en[k] && add_reg[k] == REG_W'(r))
          dep_nx[r][add_slot] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n) dep[r] <= '0;
      else        dep[r] <= dep_nx[r];
    end
  end

  always_comb begin
    waiting = '0;
    for (int r = 0; r < NREG; r++)
      waiting = waiting | dep[r];
  end

  assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |=> (dep[$past(wake_reg)] == '0));

  for (genvar k = 0; k < NADD; k++) begin : g_chk
    assert_no_add_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      add_en[k] |-> !(wake_en && wake_reg == add_reg[k]));
  end
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard #(
  parameter int NUM_INT_REGS = 16,
  parameter int NUM_FP_REGS  = 16,
  parameter int NUM_SLOTS    = 8,
  parameter int IDX_W        = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ins_valid,
  output logic                         ins_ready,
  input  logic [$clog2(NUM_SLOTS)-1:0] ins_slot,
  input  logic                         ins_src0_en,
  input  logic                         ins_src0_fp,
  input  logic [IDX_W-1:0]             ins_src0_idx,
  input  logic                         ins_src1_en,
  input  logic                         ins_src1_fp,
  input  logic [IDX_W-1:0]             ins_src1_idx,
  input  logic                         ins_dst_en,
  input  logic                         ins_dst_fp,
  input  logic [IDX_W-1:0]             ins_dst_idx,
  input  logic                         cmp_valid,
  input  logic                         cmp_fp,
  input  logic [IDX_W-1:0]             cmp_idx,
  output logic [NUM_SLOTS-1:0]         slot_ready
);
  import wsb_pkg::*;

  localparam int NREG   = NUM_INT_REGS + NUM_FP_REGS;
  localparam int REG_W  = $clog2(NREG);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  // Operand folding into the unified register space.
  logic             op_fp   [NUM_OPS];
  logic [IDX_W-1:0] op_idx  [NUM_OPS];
  logic [REG_W-1:0] op_phys [NUM_OPS];
  logic [REG_W-1:0] cmp_phys;

  assign op_fp[OP_SRC0]  = ins_src0_fp;
  assign op_idx[OP_SRC0] = ins_src0_idx;
  assign op_fp[OP_SRC1]  = ins_src1_fp;
  assign op_idx[OP_SRC1] = ins_src1_idx;
  assign op_fp[OP_DST]   = ins_dst_fp;
  assign op_idx[OP_DST]  = ins_dst_idx;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_fold
    wsb_regfold #(.NUM_INT(NUM_INT_REGS), .IDX_W(IDX_W), .REG_W(REG_W)) u_fold (
      .is_fp (op_fp[g]),
      .idx   (op_idx[g]),
      .phys  (op_phys[g])
    );
  end

  wsb_regfold #(.NUM_INT(NUM_INT_REGS), .IDX_W(IDX_W), .REG_W(REG_W)) u_fold_cmp (
    .is_fp (cmp_fp),
    .idx   (cmp_idx),
    .phys  (cmp_phys)
  );

  // Slot occupancy and insert handshake.
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] waiting;
  logic [NUM_SLOTS-1:0] fire;
  logic                 accept;

  assign ins_ready = !pend[ins_slot];
  assign accept    = ins_valid && ins_ready;

  // Source lookup with same-cycle completion bypass.
  logic [REG_W-1:0]    src_phys [NUM_SRCS];
  logic [NUM_SRCS-1:0] src_en;
  logic [NUM_SRCS-1:0] src_avail;
  logic [NUM_SRCS-1:0] bypass;
  logic [NUM_SRCS-1:0] need;
  logic [NUM_SRCS-1:0] add_en;

  assign src_en[OP_SRC0] = ins_src0_en;
  assign src_en[OP_SRC1] = ins_src1_en;

  for (genvar k = 0; k < NUM_SRCS; k++) begin : g_src
    assign src_phys[k] = op_phys[k];
    assign bypass[k]   = cmp_valid && (cmp_phys == src_phys[k]);
    assign need[k]     = src_en[k] && !src_avail[k] && !bypass[k];
    assign add_en[k]   = accept && need[k];
  end

  wsb_avail #(.NREG(NREG), .REG_W(REG_W), .NRD(NUM_SRCS)) u_avail (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (cmp_valid),
    .set_reg  (cmp_phys),
    .clr_en   (accept && ins_dst_en),
    .clr_reg  (op_phys[OP_DST]),
    .rd_reg   (src_phys),
    .rd_avail (src_avail)
  );

  wsb_depmat #(.NREG(NREG), .SLOTS(NUM_SLOTS), .REG_W(REG_W), .SLOT_W(SLOT_W),
               .NADD(NUM_SRCS)) u_dep (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (add_en),
    .add_reg  (src_phys),
    .add_slot (ins_slot),
    .wake_en  (cmp_valid),
    .wake_reg (cmp_phys),
    .waiting  (waiting)
  );

  // A slot reports once when occupied and no longer waiting.
  assign fire       = pend & ~waiting;
  assign slot_ready = fire;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '0;
    else
      pend <= (pend & ~fire) | (accept ? (NUM_SLOTS'(1) << ins_slot) : '0);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_ready[s] |=> !slot_ready[s]);

    assert_clean_insert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ins_slot == SLOT_W'(s) && need == '0) |=> slot_ready[s]);

    assert_busy_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_slot == SLOT_W'(s) && slot_ready[s]) |-> !ins_ready);
  end
endmodule

// File: tb/sim_wakeup_scoreboard.sv
`timescale 1ns/1ps
module sim_wakeup_scoreboard;
  localparam int NI = 16;
  localparam int NF = 16;
  localparam int SL = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ins_valid, ins_ready;
  logic [2:0]    ins_slot;
  logic          ins_src0_en, ins_src0_fp, ins_src1_en, ins_src1_fp;
  logic          ins_dst_en, ins_dst_fp, cmp_valid, cmp_fp;
  logic [IW-1:0] ins_src0_idx, ins_src1_idx, ins_dst_idx, cmp_idx;
  logic [SL-1:0] slot_ready;

  always #2.5 clk = ~clk;

  wakeup_scoreboard #(.NUM_INT_REGS(NI), .NUM_FP_REGS(NF), .NUM_SLOTS(SL), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_slot(ins_slot),
    .ins_src0_en(ins_src0_en), .ins_src0_fp(ins_src0_fp), .ins_src0_idx(ins_src0_idx),
    .ins_src1_en(ins_src1_en), .ins_src1_fp(ins_src1_fp), .ins_src1_idx(ins_src1_idx),
    .ins_dst_en(ins_dst_en), .ins_dst_fp(ins_dst_fp), .ins_dst_idx(ins_dst_idx),
    .cmp_valid(cmp_valid), .cmp_fp(cmp_fp), .cmp_idx(cmp_idx),
    .slot_ready(slot_ready)
  );

  typedef struct {
    int            at;
    logic [SL-1:0] mask;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected ready masks due this cycle and compares.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [SL-1:0] em;
      string         t;
      em = '0;
      t  = "R8";
      while (q.size() > 0 && q[0].at == cyc) begin
        em = em | q[0].mask;
        t  = q[0].tag;
        void'(q.pop_front());
      end
      if (em != '0 || slot_ready != '0) begin
        checks++;
        if (slot_ready !== em) begin
          fails++;
          $display("FAIL %s slot_ready actual=%0h expected=%0h", t, slot_ready, em);
        end
      end
    end
  end

  task automatic clear_inputs();
    ins_valid = 0; ins_slot = '0;
    ins_src0_en = 0; ins_src0_fp = 0; ins_src0_idx = '0;
    ins_src1_en = 0; ins_src1_fp = 0; ins_src1_idx = '0;
    ins_dst_en = 0;  ins_dst_fp = 0;  ins_dst_idx = '0;
    cmp_valid = 0;   cmp_fp = 0;      cmp_idx = '0;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected pulse.
  task automatic step(input bit iv, input int sl,
                      input bit ae, input bit af, input int ai,
                      input bit be, input bit bf, input int bi,
                      input bit de, input bit df, input int di,
                      input bit ce, input bit cf, input int ci,
                      input logic [SL-1:0] em, input string tag);
    exp_t e;
    ins_valid = iv; ins_slot = sl[2:0];
    ins_src0_en = ae; ins_src0_fp = af; ins_src0_idx = ai[IW-1:0];
    ins_src1_en = be; ins_src1_fp = bf; ins_src1_idx = bi[IW-1:0];
    ins_dst_en = de;  ins_dst_fp = df;  ins_dst_idx = di[IW-1:0];
    cmp_valid = ce;   cmp_fp = cf;      cmp_idx = ci[IW-1:0];
    if (em != '0) begin
      e.at = cyc + 1; e.mask = em; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic ins(input int sl,
                     input bit ae, input bit af, input int ai,
                     input bit be, input bit bf, input int bi,
                     input bit de, input bit df, input int di,
                     input logic [SL-1:0] em, input string tag);
    step(1, sl, ae, af, ai, be, bf, bi, de, df, di, 0, 0, 0, em, tag);
  endtask

  task automatic cmpl(input bit cf, input int ci, input logic [SL-1:0] em,
                      input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, cf, ci, em, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(slot_ready == '0, "R1", "slot_ready after reset", int'(slot_ready), 0);
    chk(ins_ready == 1'b1, "R1", "ins_ready after reset", int'(ins_ready), 1);

    // R1 / R4: all registers available after reset, sources int3 and fp3
    ins(0, 1, 0, 3, 1, 1, 3, 1, 0, 5, 8'h01, "R1");
    idle(1);
    chk(slot_ready == '0, "R8", "no second pulse", int'(slot_ready), 0);

    // R5 / R6: int5 pending; slot1 waits on int5, slot2 on int5 and int6
    ins(1, 1, 0, 5, 0, 0, 0, 1, 0, 6, 8'h00, "R5");
    ins(2, 1, 0, 5, 1, 0, 6, 0, 0, 0, 8'h00, "R6");
    idle(2);
    chk(slot_ready == '0, "R5", "consumers held", int'(slot_ready), 0);
    cmpl(0, 5, 8'h02, "R5");
    cmpl(0, 6, 8'h04, "R6");

    // R2: fp5 is distinct from int5
    ins(3, 0, 0, 0, 0, 0, 0, 1, 1, 5, 8'h08, "R4");
    ins(4, 1, 0, 5, 0, 0, 0, 0, 0, 0, 8'h10, "R2");
    ins(5, 1, 1, 5, 0, 0, 0, 0, 0, 0, 8'h00, "R2");
    cmpl(0, 5, 8'h00, "R10");
    chk(slot_ready == '0, "R10", "int5 completion wakes nothing", int'(slot_ready), 0);
    cmpl(1, 5, 8'h20, "R2");

    // R5: fan-out of fp9 to three slots in one completion
    ins(1, 0, 0, 0, 0, 0, 0, 1, 1, 9, 8'h02, "R4");
    ins(6, 1, 1, 9, 0, 0, 0, 0, 0, 0, 8'h00, "R5");
    ins(7, 1, 1, 9, 0, 0, 0, 0, 0, 0, 8'h00, "R5");
    ins(0, 0, 0, 0, 1, 1, 9, 0, 0, 0, 8'h00, "R5");
    cmpl(1, 9, 8'hC1, "R5");

    // R7: source completing in the insert cycle counts as available
    ins(2, 0, 0, 0, 0, 0, 0, 1, 0, 2, 8'h04, "R4");
    step(1, 3, 1, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 2, 8'h08, "R7");

    // R9: refused insert into occupied slot leaves no trace
    ins(4, 0, 0, 0, 0, 0, 0, 1, 1, 12, 8'h10, "R4");
    ins(5, 0, 0, 0, 0, 0, 0, 1, 0, 7, 8'h20, "R4");
    ins(6, 1, 0, 7, 0, 0, 0, 0, 0, 0, 8'h00, "R9");
    ins_valid = 1; ins_slot = 3'd6;
    ins_src0_en = 1; ins_src0_fp = 1; ins_src0_idx = 4'd12;
    #1;
    chk(ins_ready == 1'b0, "R9", "ins_ready for busy slot", int'(ins_ready), 0);
    @(negedge clk);
    clear_inputs();
    cmpl(0, 7, 8'h40, "R9");

    // R3: producer insert and completion of int9 in the same cycle
    step(1, 7, 0, 0, 0, 0, 0, 0, 1, 0, 9, 1, 0, 9, 8'h80, "R3");
    ins(0, 1, 0, 9, 0, 0, 0, 0, 0, 0, 8'h00, "R3");
    idle(2);
    chk(slot_ready == '0, "R3", "int9 left pending", int'(slot_ready), 0);
    cmpl(0, 9, 8'h01, "R3");

    idle(3);
    chk(q.size() == 0, "R8", "expected pulses outstanding", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule